// File: doc/BRIEF.md
# Address Table Command Engine

This block holds a small table of learned station addresses, such as the forwarding database of an Ethernet switch, and changes or searches it on command. Software first writes up to three 32-bit data words that describe one entry: a 48-bit MAC address, a 7-bit port mask, a 4-bit status and a 12-bit VLAN identifier. It then writes a function word that carries an operation code, an optional port filter and a start bit. The engine raises busy and runs the operation against its internal entry array, one slot per clock. When it finishes it clears busy and, where the operation calls for it, reports a full condition or writes a found entry back into the data words.

Four operations are supported. Flush empties every slot. Load adds an entry or updates one already present. Purge removes an entry. Next walks the table: each call returns the entry that follows the one whose key is currently held in the data words. Repeated calls therefore step through all valid entries. When a port filter is enabled, only entries whose port mask includes that port are returned.

The controller is a single state machine with eight states:
- S_IDLE waits for busy.
- S_FLUSH clears one slot per cycle.
- S_LOAD_SCAN sweeps every slot, noting the first slot whose key matches and the lowest empty slot.
- S_LOAD_COMMIT writes the entry, or flags the table full.
- S_PURGE_SCAN sweeps until it hits a matching key or reaches the last slot.
- S_SEEK_KEY locates the iteration key.
- S_NEXT_SCAN searches onward from the slot after the key for the next selectable entry.
- S_FINISH pulses done for one cycle.

The transitions are:
- S_IDLE goes, by operation code, to S_FLUSH, S_LOAD_SCAN, S_PURGE_SCAN, or to S_SEEK_KEY for a next with a nonzero key. A next with an all-zero key goes to S_NEXT_SCAN. Any other code goes to S_FINISH.
- S_FLUSH, S_PURGE_SCAN and S_NEXT_SCAN advance through the slots and go to S_FINISH at the last slot or on a hit.
- S_LOAD_SCAN goes to S_LOAD_COMMIT after the last slot.
- S_SEEK_KEY goes to S_NEXT_SCAN on a hit before the last slot, and otherwise to S_FINISH at the last slot.
- S_LOAD_COMMIT goes to S_FINISH.
- S_FINISH returns to S_IDLE.

Top module: `mac_table_engine`

## Requirements
- R1: The register addresses are 0, 1 and 2 for the three data words and 3 for the function word. An entry's fields sit in the data words as follows:
  - The MAC address is in word0[31:0] and word1[15:0]. MAC byte 0 is word1[15:8] and byte 5 is word0[7:0].
  - The port mask is in word1[22:16].
  - The status is in word2[3:0].
  - The VLAN identifier is in word2[19:8].
  - Word1[31:23], word2[7:4] and word2[31:20] are zero in any entry the engine writes back.
- R2: The function word reads back with the following fields:
  - Bit 31 is busy.
  - Bit 15 is port-filter enable.
  - Bit 12 is full.
  - Bits [10:8] are the port number.
  - Bits [2:0] are the operation: 1 flush, 2 load, 3 purge, 4 next. Any other code completes without effect.
  - All other bits read 0. After reset every register reads 0.
- R3: A function write with bit 31 set while busy is clear starts the operation and sets busy. Busy stays set until the engine clears it on completion. A function write made while busy is set is ignored.
- R4: Flush leaves every slot empty (status 0).
- R5: A load whose key (MAC plus VLAN) matches no valid entry stores the entry in the lowest-index empty slot.
- R6: A load whose key matches a valid entry overwrites that entry in place and takes no new slot.
- R7: A load that finds neither a match nor an empty slot leaves the table unchanged and sets full. Full is cleared when the next operation starts.
- R8: Purge empties the valid entry whose key matches. Without a match it completes with the table unchanged and full clear. Purge does not change the data words.
- R9: Next with an all-zero key (MAC 0 and VLAN 0) writes the lowest-index selectable valid entry into the data words.
- R10: Next with a nonzero key returns the first selectable valid entry in a slot after the slot holding that key. If there is none, or the key is not in the table, it writes zero to all three data words, so that status reads 0.
- R11: When port-filter enable is set, next skips entries whose port mask bit at the given port number is 0.
- R12: Writes to the data words while busy is set are ignored.
- R13: An entry with status 0 is empty. Next never returns it, and load or purge never match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address (0 to 2 data, 3 function) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data for reg_raddr, combinational |

## Verification
A wrong internal state shows at the ports no later than the completion of the next operation that touches it. A scan index that skips or repeats a slot makes a later next return an entry out of slot order, or zeros where an entry was expected. A lost match or free flag makes a load take a second slot, which a following walk exposes as a duplicate, or makes it report full on a table that still has an empty slot. A busy bit that clears early lets a data write through, and the write shows in the data words as soon as the operation ends.

// File: rtl/mat_pkg.sv
package mat_pkg;

    localparam int MAC_W  = 48;
    localparam int MASK_W = 7;
    localparam int STAT_W = 4;
    localparam int VID_W  = 12;
    localparam int PORT_W = $clog2(MASK_W);

    // function word field positions
    localparam int FN_BUSY  = 31;
    localparam int FN_PEN   = 15;
    localparam int FN_FULL  = 12;
    localparam int FN_PORT  = 8;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_FLUSH = 3'd1,
        OP_LOAD  = 3'd2,
        OP_PURGE = 3'd3,
        OP_NEXT  = 3'd4
    } op_e;

    typedef struct packed {
        logic [VID_W-1:0]  vid;
        logic [STAT_W-1:0] status;
        logic [MASK_W-1:0] mask;
        logic [MAC_W-1:0]  mac;
    } entry_t;

    // 96-bit image of the three data words, word0 in the low bits
    function automatic logic [95:0] entry_to_words(entry_t e);
        return {12'b0, e.vid, 4'b0, e.status, 9'b0, e.mask, e.mac};
    endfunction

    function automatic entry_t words_to_entry(logic [95:0] w);
        entry_t e;
        e.mac    = w[47:0];
        e.mask   = w[54:48];
        e.status = w[67:64];
        e.vid    = w[83:72];
        return e;
    endfunction

endpackage

// File: rtl/mat_regs.sv
module mat_regs
    import mat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              done,
    input  logic              set_full,
    input  logic              wb_en,
    input  entry_t            wb_entry,
    output entry_t            key,
    output logic [2:0]        op,
    output logic              port_en,
    output logic [PORT_W-1:0] port_num,
    output logic              busy
);

    logic [31:0] w0_q, w1_q, w2_q;
    logic        full_q;
    logic [95:0] wb_words;
    logic        wr_ok;

    assign wb_words = entry_to_words(wb_entry);
    assign wr_ok    = wr_en && !busy;
    assign key      = words_to_entry({w2_q, w1_q, w0_q});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0_q     <= '0;
            w1_q     <= '0;
            w2_q     <= '0;
            op       <= '0;
            port_en  <= 1'b0;
            port_num <= '0;
            busy     <= 1'b0;
            full_q   <= 1'b0;
        end else begin
            if (wb_en) begin
                w0_q <= wb_words[31:0];
                w1_q <= wb_words[63:32];
                w2_q <= wb_words[95:64];
            end else if (wr_ok) begin
                case (wr_addr)
                    2'd0:    w0_q <= wr_data;
                    2'd1:    w1_q <= wr_data;
                    2'd2:    w2_q <= wr_data;
                    default: ;
                endcase
            end
            if (done) begin
                busy <= 1'b0;
            end
            if (set_full) begin
                full_q <= 1'b1;
            end
            if (wr_ok && wr_addr == 2'd3) begin
                op       <= wr_data[2:0];
                port_en  <= wr_data[FN_PEN];
                port_num <= wr_data[FN_PORT +: PORT_W];
                if (wr_data[FN_BUSY]) begin
                    busy   <= 1'b1;
                    full_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            2'd0: rd_data = w0_q;
            2'd1: rd_data = w1_q;
            2'd2: rd_data = w2_q;
            default: begin
                rd_data[FN_BUSY]             = busy;
                rd_data[FN_PEN]              = port_en;
                rd_data[FN_FULL]             = full_q;
                rd_data[FN_PORT +: PORT_W]   = port_num;
                rd_data[2:0]                 = op;
            end
        endcase
    end

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R3

    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !wb_en |=> $stable(w0_q) && $stable(w1_q) && $stable(w2_q)); // R12

    AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> op == OP_LOAD); // R7

endmodule

// File: rtl/mat_store.sv
module mat_store
    import mat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_entry,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_entry
);

    entry_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                slot_q[g] <= wr_entry;
            end
        end
    end

    assign rd_entry = slot_q[rd_idx];

endmodule

// File: rtl/mat_ctrl.sv
module mat_ctrl
    import mat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int MX    = 1 << PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [2:0]        op,
    input  logic              port_en,
    input  logic [PORT_W-1:0] port_num,
    input  entry_t            key,
    output logic [IDX_W-1:0]  rd_idx,
    input  entry_t            rd_entry,
    output logic              st_wr_en,
    output logic [IDX_W-1:0]  st_wr_idx,
    output entry_t            st_wr_entry,
    output logic              wb_en,
    output entry_t            wb_entry,
    output logic              set_full,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_FLUSH,
        S_LOAD_SCAN,
        S_LOAD_COMMIT,
        S_PURGE_SCAN,
        S_SEEK_KEY,
        S_NEXT_SCAN,
        S_FINISH
    } state_e;

    state_e           state, nxt_state;
    logic [IDX_W-1:0] idx, nxt_idx;
    logic             have_match, nxt_have_match;
    logic [IDX_W-1:0] match_idx, nxt_match_idx;
    logic             have_free, nxt_have_free;
    logic [IDX_W-1:0] free_idx, nxt_free_idx;

    logic             slot_valid, key_hit, key_zero, at_last, port_sel;
    logic [MX-1:0]    mask_ext;

    assign rd_idx     = idx;
    assign slot_valid = rd_entry.status != '0;
    assign key_hit    = slot_valid && rd_entry.mac == key.mac && rd_entry.vid == key.vid;
    assign key_zero   = key.mac == '0 && key.vid == '0;
    assign at_last    = idx == LAST;
    assign mask_ext   = MX'(rd_entry.mask);
    assign port_sel   = !port_en || mask_ext[port_num];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // scan datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            have_match <= 1'b0;
            match_idx  <= '0;
            have_free  <= 1'b0;
            free_idx   <= '0;
        end else begin
            idx        <= nxt_idx;
            have_match <= nxt_have_match;
            match_idx  <= nxt_match_idx;
            have_free  <= nxt_have_free;
            free_idx   <= nxt_free_idx;
        end
    end

    // transitions
    always_comb begin
        nxt_state      = state;
        nxt_idx        = idx;
        nxt_have_match = have_match;
        nxt_match_idx  = match_idx;
        nxt_have_free  = have_free;
        nxt_free_idx   = free_idx;
        unique case (state)
            S_IDLE: begin
                if (busy) begin
                    nxt_idx        = '0;
                    nxt_have_match = 1'b0;
                    nxt_have_free  = 1'b0;
                    case (op)
                        OP_FLUSH: nxt_state = S_FLUSH;
                        OP_LOAD:  nxt_state = S_LOAD_SCAN;
                        OP_PURGE: nxt_state = S_PURGE_SCAN;
                        OP_NEXT:  nxt_state = key_zero ? S_NEXT_SCAN : S_SEEK_KEY;
                        default:  nxt_state = S_FINISH;
                    endcase
                end
            end
            S_FLUSH: begin
                if (at_last) nxt_state = S_FINISH;
                else         nxt_idx   = idx + 1'b1;
            end
            S_LOAD_SCAN: begin
                if (key_hit && !have_match) begin
                    nxt_have_match = 1'b1;
                    nxt_match_idx  = idx;
                end
                if (!slot_valid && !have_free) begin
                    nxt_have_free = 1'b1;
                    nxt_free_idx  = idx;
                end
                if (at_last) nxt_state = S_LOAD_COMMIT;
                else         nxt_idx   = idx + 1'b1;
            end
            S_LOAD_COMMIT: begin
                nxt_state = S_FINISH;
            end
            S_PURGE_SCAN: begin
                if (key_hit || at_last) nxt_state = S_FINISH;
                else                    nxt_idx   = idx + 1'b1;
            end
            S_SEEK_KEY: begin
                if (at_last) begin
                    nxt_state = S_FINISH;
                end else begin
                    nxt_idx = idx + 1'b1;
                    if (key_hit) nxt_state = S_NEXT_SCAN;
                end
            end
            S_NEXT_SCAN: begin
                if ((slot_valid && port_sel) || at_last) nxt_state = S_FINISH;
                else                                     nxt_idx   = idx + 1'b1;
            end
            S_FINISH: begin
                nxt_state = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        st_wr_en    = 1'b0;
        st_wr_idx   = idx;
        st_wr_entry = '0;
        wb_en       = 1'b0;
        wb_entry    = '0;
        set_full    = 1'b0;
        done        = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_FLUSH: begin
                st_wr_en = 1'b1;
            end
            S_LOAD_SCAN: ;
            S_LOAD_COMMIT: begin
                st_wr_entry = key;
                if (have_match) begin
                    st_wr_en  = 1'b1;
                    st_wr_idx = match_idx;
                end else if (have_free) begin
                    st_wr_en  = 1'b1;
                    st_wr_idx = free_idx;
                end else begin
                    set_full = 1'b1;
                end
            end
            S_PURGE_SCAN: begin
                st_wr_en = key_hit;
            end
            S_SEEK_KEY: begin
                wb_en = at_last;
            end
            S_NEXT_SCAN: begin
                if (slot_valid && port_sel) begin
                    wb_en    = 1'b1;
                    wb_entry = rd_entry;
                end else if (at_last) begin
                    wb_en = 1'b1;
                end
            end
            S_FINISH: begin
                done = 1'b1;
            end
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idx) < DEPTH); // R4

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !st_wr_en && !wb_en); // R12

endmodule

// File: rtl/mac_table_engine.sv
module mac_table_engine
    import mat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  reg_raddr,
    output logic [31:0] reg_rdata
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    entry_t            key, rd_entry, st_wr_entry, wb_entry;
    logic [2:0]        op;
    logic              port_en, busy, done, set_full, wb_en, st_wr_en;
    logic [PORT_W-1:0] port_num;
    logic [IDX_W-1:0]  rd_idx, st_wr_idx;

    mat_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_waddr),
        .wr_data  (reg_wdata),
        .rd_addr  (reg_raddr),
        .rd_data  (reg_rdata),
        .done     (done),
        .set_full (set_full),
        .wb_en    (wb_en),
        .wb_entry (wb_entry),
        .key      (key),
        .op       (op),
        .port_en  (port_en),
        .port_num (port_num),
        .busy     (busy)
    );

    mat_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .wr_en    (st_wr_en),
        .wr_idx   (st_wr_idx),
        .wr_entry (st_wr_entry)
    );

    mat_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .op          (op),
        .port_en     (port_en),
        .port_num    (port_num),
        .key         (key),
        .rd_idx      (rd_idx),
        .rd_entry    (rd_entry),
        .st_wr_en    (st_wr_en),
        .st_wr_idx   (st_wr_idx),
        .st_wr_entry (st_wr_entry),
        .wb_en       (wb_en),
        .wb_entry    (wb_entry),
        .set_full    (set_full),
        .done        (done)
    );

endmodule

// File: tb/sim_mac_table_engine.sv
`timescale 1ns/1ps
module sim_mac_table_engine;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;

    int vectors = 0;
    int errors  = 0;

    bit [47:0] m_mac  [D];
    bit [11:0] m_vid  [D];
    bit [6:0]  m_mask [D];
    bit [3:0]  m_st   [D];
    bit [31:0] md     [3];
    bit        m_full;

    always #10 clk = ~clk;

    mac_table_engine #(.DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit [1:0] a, input bit [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit [1:0] a, output bit [31:0] v);
        reg_raddr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic set_key(input bit [47:0] mac, input bit [11:0] vid,
                           input bit [6:0] mask, input bit [3:0] st);
        md[0] = mac[31:0];
        md[1] = {9'b0, mask, mac[47:32]};
        md[2] = {12'b0, vid, 4'b0, st};
        for (int k = 0; k < 3; k++) wr(2'(k), md[k]);
    endtask

    function automatic int find_key(bit [47:0] mac, bit [11:0] vid);
        for (int i = 0; i < D; i++)
            if (m_st[i] != 0 && m_mac[i] == mac && m_vid[i] == vid) return i;
        return -1;
    endfunction

    task automatic model(input bit [2:0] op, input bit pen, input bit [2:0] pn);
        bit [47:0] km;
        bit [11:0] kv;
        int j;
        int start;
        km = {md[1][15:0], md[0]};
        kv = md[2][19:8];
        m_full = 0;
        case (op)
            3'd1: for (int i = 0; i < D; i++) begin
                m_mac[i] = 0; m_vid[i] = 0; m_mask[i] = 0; m_st[i] = 0;
            end
            3'd2: begin
                j = find_key(km, kv);
                if (j < 0)
                    for (int i = D - 1; i >= 0; i--) if (m_st[i] == 0) j = i;
                if (j < 0) m_full = 1;
                else begin
                    m_mac[j] = km; m_vid[j] = kv; m_mask[j] = md[1][22:16]; m_st[j] = md[2][3:0];
                end
            end
            3'd3: begin
                j = find_key(km, kv);
                if (j >= 0) begin
                    m_mac[j] = 0; m_vid[j] = 0; m_mask[j] = 0; m_st[j] = 0;
                end
            end
            3'd4: begin
                if (km == 0 && kv == 0) start = 0;
                else begin
                    j = find_key(km, kv);
                    start = (j < 0) ? D : j + 1;
                end
                md[0] = 0; md[1] = 0; md[2] = 0;
                for (int i = start; i < D; i++) begin
                    if (m_st[i] != 0 && (!pen || m_mask[i][pn])) begin
                        md[0] = m_mac[i][31:0];
                        md[1] = {9'b0, m_mask[i], m_mac[i][47:32]};
                        md[2] = {12'b0, m_vid[i], 4'b0, m_st[i]};
                        break;
                    end
                end
            end
            default: ;
        endcase
    endtask

    // poke: write data and function words while busy (both must be ignored)
    task automatic cmd(input string tag, input bit [2:0] op, input bit pen,
                       input bit [2:0] pn, input bit poke);
        bit [31:0] v;
        bit [31:0] fexp;
        int n;
        wr(2'd3, 32'h8000_0000 | (32'(pen) << 15) | (32'(pn) << 8) | 32'(op));
        model(op, pen, pn);
        rd(2'd3, v);
        check({tag, " R3 busy set"}, {31'b0, v[31]}, 32'd1);
        if (poke) begin
            wr(2'd0, 32'hDEAD_BEEF);
            wr(2'd3, 32'h0000_0002);
        end
        n = 0;
        rd(2'd3, v);
        while (v[31] && n < 400) begin
            @(negedge clk);
            rd(2'd3, v);
            n++;
        end
        fexp = (32'(pen) << 15) | (32'(m_full) << 12) | (32'(pn) << 8) | 32'(op);
        check({tag, " R2 function word"}, v, fexp);
        for (int k = 0; k < 3; k++) begin
            rd(2'(k), v);
            check($sformatf("%s R1 word%0d", tag, k), v, md[k]);
        end
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        bit [31:0] v;
        int cnt;
        for (int i = 0; i < D; i++) begin
            m_mac[i] = 0; m_vid[i] = 0; m_mask[i] = 0; m_st[i] = 0;
        end
        md[0] = 0; md[1] = 0; md[2] = 0; m_full = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 4; k++) begin
            rd(2'(k), v);
            check("R2 reset value", v, 32'd0);
        end

        cmd("R4 flush", 3'd1, 0, 0, 0);
        cmd("R10 empty table walk", 3'd4, 0, 0, 0);

        set_key(48'h0011_2233_4455, 12'd5, 7'b0000010, 4'hF);
        cmd("R5 load A", 3'd2, 0, 0, 0);
        set_key(0, 0, 0, 0);
        cmd("R9 next from zero", 3'd4, 0, 0, 0);
        cmd("R10 next past last", 3'd4, 0, 0, 0);

        set_key(48'hA0B0_C0D0_E0F0, 12'd7, 7'b0001000, 4'h7);
        cmd("R5 load B", 3'd2, 0, 0, 0);
        set_key(48'h0102_0304_0506, 12'd9, 7'b0000110, 4'h3);
        cmd("R5 load C", 3'd2, 0, 0, 0);

        set_key(0, 0, 0, 0);
        cmd("R11 filter port3", 3'd4, 1, 3'd3, 0);
        cmd("R11 filter port3 again", 3'd4, 1, 3'd3, 0);
        set_key(0, 0, 0, 0);
        cmd("R11 filter port1 first", 3'd4, 1, 3'd1, 0);
        cmd("R11 filter port1 second", 3'd4, 1, 3'd1, 0);
        cmd("R11 filter port1 end", 3'd4, 1, 3'd1, 0);

        set_key(48'h0011_2233_4455, 12'd5, 7'b1000000, 4'hF);
        cmd("R6 overwrite A", 3'd2, 0, 0, 0);
        set_key(0, 0, 0, 0);
        cmd("R6 walk 1", 3'd4, 0, 0, 0);
        cmd("R6 walk 2", 3'd4, 0, 0, 0);
        cmd("R6 walk 3", 3'd4, 0, 0, 0);
        cmd("R6 walk 4", 3'd4, 0, 0, 0);

        set_key(48'hA0B0_C0D0_E0F0, 12'd7, 0, 0);
        cmd("R8 purge B", 3'd3, 0, 0, 0);
        cmd("R8 purge again no match", 3'd3, 0, 0, 0);
        set_key(48'h7777_7777_7777, 12'd1, 7'b0000001, 4'h5);
        cmd("R13 reuse emptied slot", 3'd2, 0, 0, 0);
        set_key(0, 0, 0, 0);
        cmd("R13 walk 1", 3'd4, 0, 0, 0);
        cmd("R13 walk 2", 3'd4, 0, 0, 0);
        cmd("R13 walk 3", 3'd4, 0, 0, 0);
        cmd("R13 walk 4", 3'd4, 0, 0, 0);

        set_key(48'h5555_0000_0001, 12'd3, 0, 0);
        cmd("R10 absent key", 3'd4, 0, 0, 0);
        set_key(48'h0000_0000_0000, 12'd44, 7'b1, 4'h1);
        cmd("R3 unknown op", 3'd6, 0, 0, 0);
        cmd("R12 flush with pokes", 3'd1, 0, 0, 1);

        for (int i = 0; i < D; i++) begin
            set_key(48'h0200_0000_0000 + 48'(i), 12'(i + 1), 7'(1 << (i % 7)), (i % 2) ? 4'hF : 4'h5);
            cmd("R5 fill", 3'd2, 0, 0, 0);
        end
        set_key(48'h0300_0000_0000, 12'd99, 7'b1, 4'h5);
        cmd("R7 load into full table", 3'd2, 0, 0, 0);
        set_key(48'h0200_0000_0004, 12'd5, 7'b0010000, 4'h9);
        cmd("R7 overwrite clears full", 3'd2, 0, 0, 0);

        set_key(0, 0, 0, 0);
        cnt = 0;
        for (int i = 0; i < D + 1; i++) begin
            cmd("R9 full walk", 3'd4, 0, 0, 0);
            if (md[2][3:0] != 0) cnt++;
        end
        check("R6 walk count", 32'(cnt), 32'(D));

        set_key(0, 0, 0, 0);
        for (int i = 0; i < 4; i++) cmd("R11 full walk port4", 3'd4, 1, 3'd4, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule